// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital control around a 12-bit analog-to-digital converter. It tracks the converter through three phases: idle, acquisition (the sample/hold switch closed) and conversion. A trigger ends acquisition and starts conversion. A 3-bit selector picks where that trigger comes from: the falling edge of a software sample bit, a timer strobe, an external strobe, or a self-timed auto-convert mode. In auto-convert mode acquisition lasts a programmed number of conversion-clock periods. The next acquisition then begins on its own as soon as each result lands.

The conversion clock comes from a 6-bit divider. Its period is `(div+1)/2` system clocks, counted in system-clock half-periods. A select bit can instead count the strobes of a separate clock-enable input, which models an internal RC oscillator. A conversion lasts 14 conversion-clock periods. At its end the result word supplied on `conv_data` is written into the result register and `done` pulses for one cycle. Dropping the enable aborts any phase at once and leaves the result register untouched. Software may also write the result register directly.

The result leaves the block as a register qualified by a one-cycle `done` strobe. There is no back-pressure: a consumer must capture `result` while `done` is high, or before the next completion overwrites it. All other pins are plain control and status levels.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `sample_hold`, `conv_busy` and `done` are 0 and `result` is 0.
- R2: While `enable` is 1 and the block is idle, a rising edge of `samp_sw` starts acquisition. `sample_hold` is 1 from the cycle after the clock edge that sees the rise. A rise during acquisition or conversion has no effect.
- R3: With `trig_src` = 3'b000, the clock edge that sees `samp_sw` fall ends acquisition. From the next cycle `conv_busy` is 1 and `sample_hold` is 0.
- R4: With `trig_src` = 3'b111, acquisition lasts T(S) cycles, where S = `samp_cnt`, or 1 when `samp_cnt` is 0. Conversion then follows. When the conversion completes, `sample_hold` is 1 again in the same cycle as `done`. Falls of `samp_sw` are ignored in this mode.
- R5: With `trig_src` = 3'b001 a pulse on `ext_strobe` ends acquisition, and with 3'b010 a pulse on `tmr_strobe` does. The other strobe and falls of `samp_sw` are ignored in both cases. Codes 3'b011 to 3'b110 provide no trigger, so acquisition holds.
- R6: With `rc_sel` = 0, `conv_busy` stays high for T(14) cycles. T(k) = k when `clk_div` is 0, and otherwise ceil(k·(`clk_div`+1)/2). Period counting restarts at the start of each phase, and `rc_tick` is ignored.
- R7: With `rc_sel` = 1, each cycle with `rc_tick` high counts one conversion-clock period. With `rc_tick` held high, T(k) = k. With it held low, the phase never ends.
- R8: When a conversion completes, `done` is 1 for exactly the following cycle. In that same cycle `result` shows the `conv_data` value sampled on the final clock edge of the conversion.
- R9: A clock edge that sees `enable` at 0 returns the block to idle. A conversion in progress is abandoned: no `done`, and `result` is kept. Acquisition does not resume until a new rise of `samp_sw`.
- R10: If `enable` is 0 on the edge where auto-convert would start a conversion, no conversion begins.
- R11: When `buf_we` is 1, `result` shows `buf_wdata` from the next cycle. If a conversion completes on the same edge, the conversion value is written instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable; 0 aborts and idles |
| samp_sw | input | 1 | Software sample bit |
| trig_src | input | 3 | Trigger-source select |
| samp_cnt | input | 5 | Auto-convert acquisition length in conversion-clock periods |
| clk_div | input | 6 | Conversion-clock divider setting |
| rc_sel | input | 1 | 1 selects the RC clock-enable as conversion clock |
| rc_tick | input | 1 | RC oscillator clock-enable strobe |
| tmr_strobe | input | 1 | Timer match trigger strobe |
| ext_strobe | input | 1 | External interrupt trigger strobe |
| conv_data | input | 12 | Converter output word, taken at conversion end |
| buf_we | input | 1 | Software write enable for the result register |
| buf_wdata | input | 12 | Software write data |
| sample_hold | output | 1 | 1 during acquisition |
| conv_busy | output | 1 | 1 during conversion |
| done | output | 1 | One-cycle pulse when a conversion result is stored |
| result | output | 12 | Result register |

## Verification
The bench builds the block with its default parameters: a 6-bit divider, a 5-bit sample count, 14 periods per conversion and a 12-bit result. Every divider setting from 0 to 63 can therefore be reached. That covers the once-per-cycle case at 0, whole-cycle periods at odd settings, and the fractional 1.5-cycle-style periods at even settings, all within a few hundred cycles per conversion. The full sample-count range, including the 0-as-1 case and 31, is also reachable. The abort, same-edge abort and write-collision cases are timed directly from the T(k) formula.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_CONVERT = 2'd2
  } phase_t;

  localparam logic [2:0] TRG_SOFT = 3'b000;
  localparam logic [2:0] TRG_EXT  = 3'b001;
  localparam logic [2:0] TRG_TMR  = 3'b010;
  localparam logic [2:0] TRG_AUTO = 3'b111;
endpackage

// File: rtl/adc_tad_gen.sv
module adc_tad_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  input  logic             rc_sel,
  input  logic             rc_tick,
  output logic             tick
);
  localparam int AW = DIV_W + 2;

  logic [AW-1:0] acc;
  logic [AW-1:0] nval;
  logic [AW-1:0] sum;
  logic          div_zero;
  logic          sys_tick;

  assign nval     = AW'(div) + AW'(1);
  assign sum      = acc + AW'(2);
  assign div_zero = (div == '0);
  assign sys_tick = div_zero | (sum >= nval);
  assign tick     = run & (rc_sel ? rc_tick : sys_tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (restart || !run || rc_sel || div_zero) begin
      acc <= '0;
    end else if (sys_tick) begin
      acc <= sum - nval;
    end else begin
      acc <= sum;
    end
  end

  // R6
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc < nval);
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       samp_sw,
  input  logic       tmr_strobe,
  input  logic       ext_strobe,
  input  logic       auto_hit,
  output logic       samp_rise,
  output logic       auto_mode,
  output logic       trig
);
  logic samp_q;
  logic samp_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= samp_sw;
  end

  assign samp_rise = samp_sw & ~samp_q;
  assign samp_fall = ~samp_sw & samp_q;
  assign auto_mode = (mode == TRG_AUTO);

  always_comb begin
    unique case (mode)
      TRG_SOFT: trig = samp_fall;
      TRG_EXT:  trig = ext_strobe;
      TRG_TMR:  trig = tmr_strobe;
      TRG_AUTO: trig = auto_hit;
      default:  trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SAMC_W    = 5,
  parameter int CONV_TADS = 14,
  parameter int RES_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              samp_rise,
  input  logic              trig,
  input  logic              auto_mode,
  input  logic [SAMC_W-1:0] samc,
  input  logic              tick,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              buf_we,
  input  logic [RES_W-1:0]  buf_wdata,
  output phase_t            phase,
  output logic              phase_change,
  output logic              auto_hit,
  output logic              done,
  output logic [RES_W-1:0]  result
);
  localparam int CW_CONV = $clog2(CONV_TADS + 1);
  localparam int CNT_W   = (SAMC_W > CW_CONV) ? SAMC_W : CW_CONV;

  phase_t           phase_nx;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] samc_eff;
  logic             conv_end;
  logic             complete;

  assign cnt_inc  = cnt + CNT_W'(1);
  assign samc_eff = (samc == '0) ? CNT_W'(1) : CNT_W'(samc);
  assign auto_hit = (phase == PH_SAMPLE) && tick && (cnt_inc == samc_eff);
  assign conv_end = (phase == PH_CONVERT) && tick && (cnt_inc == CNT_W'(CONV_TADS));
  assign complete = enable && conv_end;

  always_comb begin
    phase_nx = phase;
    if (!enable) begin
      phase_nx = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:    if (samp_rise) phase_nx = PH_SAMPLE;
        PH_SAMPLE:  if (trig) phase_nx = PH_CONVERT;
        PH_CONVERT: if (conv_end) phase_nx = auto_mode ? PH_SAMPLE : PH_IDLE;
        default:    phase_nx = PH_IDLE;
      endcase
    end
  end

  assign phase_change = (phase_nx != phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_nx;
      if (phase_change || phase == PH_IDLE) cnt <= '0;
      else if (tick)                        cnt <= cnt_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= complete;
      if (complete)    result <= conv_data;
      else if (buf_we) result <= buf_wdata;
    end
  end

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> phase == PH_IDLE);

  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase) == PH_CONVERT);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result != $past(result)) |-> (done || $past(buf_we)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DIV_W     = 6,
  parameter int SAMC_W    = 5,
  parameter int CONV_TADS = 14,
  parameter int RES_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              samp_sw,
  input  logic [2:0]        trig_src,
  input  logic [SAMC_W-1:0] samp_cnt,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              rc_sel,
  input  logic              rc_tick,
  input  logic              tmr_strobe,
  input  logic              ext_strobe,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              buf_we,
  input  logic [RES_W-1:0]  buf_wdata,
  output logic              sample_hold,
  output logic              conv_busy,
  output logic              done,
  output logic [RES_W-1:0]  result
);
  phase_t phase;
  logic   phase_change;
  logic   auto_hit;
  logic   samp_rise;
  logic   auto_mode;
  logic   trig;
  logic   tick;

  adc_trig_sel u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (trig_src),
    .samp_sw    (samp_sw),
    .tmr_strobe (tmr_strobe),
    .ext_strobe (ext_strobe),
    .auto_hit   (auto_hit),
    .samp_rise  (samp_rise),
    .auto_mode  (auto_mode),
    .trig       (trig)
  );

  adc_tad_gen #(.DIV_W(DIV_W)) u_tad (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (phase != PH_IDLE),
    .restart (phase_change),
    .div     (clk_div),
    .rc_sel  (rc_sel),
    .rc_tick (rc_tick),
    .tick    (tick)
  );

  adc_seq_fsm #(
    .SAMC_W    (SAMC_W),
    .CONV_TADS (CONV_TADS),
    .RES_W     (RES_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .samp_rise    (samp_rise),
    .trig         (trig),
    .auto_mode    (auto_mode),
    .samc         (samp_cnt),
    .tick         (tick),
    .conv_data    (conv_data),
    .buf_we       (buf_we),
    .buf_wdata    (buf_wdata),
    .phase        (phase),
    .phase_change (phase_change),
    .auto_hit     (auto_hit),
    .done         (done),
    .result       (result)
  );

  assign sample_hold = (phase == PH_SAMPLE);
  assign conv_busy   = (phase == PH_CONVERT);

  // R3
  conv_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_busy) |-> $past(sample_hold));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        samp_sw = 1'b0;
  logic [2:0]  trig_src = 3'b000;
  logic [4:0]  samp_cnt = '0;
  logic [5:0]  clk_div = '0;
  logic        rc_sel = 1'b0;
  logic        rc_tick = 1'b0;
  logic        tmr_strobe = 1'b0;
  logic        ext_strobe = 1'b0;
  logic [11:0] conv_data = '0;
  logic        buf_we = 1'b0;
  logic [11:0] buf_wdata = '0;
  logic        sample_hold, conv_busy, done;
  logic [11:0] result;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .samp_sw(samp_sw),
    .trig_src(trig_src), .samp_cnt(samp_cnt), .clk_div(clk_div),
    .rc_sel(rc_sel), .rc_tick(rc_tick), .tmr_strobe(tmr_strobe),
    .ext_strobe(ext_strobe), .conv_data(conv_data), .buf_we(buf_we),
    .buf_wdata(buf_wdata), .sample_hold(sample_hold), .conv_busy(conv_busy),
    .done(done), .result(result)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tcy(input int k, input int div, input bit rc);
    if (rc || div == 0) return k;
    return (k * (div + 1) + 1) / 2;
  endfunction

  task automatic nedge(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_all();
    enable = 1'b0; samp_sw = 1'b0; rc_sel = 1'b0; rc_tick = 1'b0;
    nedge(2);
  endtask

  // One full conversion in software (mode 000) or auto (mode 111) mode.
  task automatic run_conv(input logic [2:0] mode, input int samc, input int div,
                          input bit rc, input logic [11:0] data, input int hold);
    int sh, bsy, s_eff;
    trig_src = mode; samp_cnt = 5'(samc); clk_div = 6'(div);
    rc_sel = rc; rc_tick = rc; conv_data = data; enable = 1'b1;
    nedge(1);
    samp_sw = 1'b1;
    nedge(1);
    sh = 0;
    while (sample_hold && sh < 4000) begin
      sh++;
      if (mode == 3'b000 && sh == hold) samp_sw = 1'b0;
      if (mode == 3'b111 && sh == 1) samp_sw = 1'b0;
      nedge(1);
    end
    s_eff = (samc == 0) ? 1 : samc;
    if (mode == 3'b111) check("R4 acquisition length", sh, tcy(s_eff, div, rc));
    else                check("R3 acquisition length", sh, hold);
    bsy = 0;
    while (conv_busy && bsy < 4000) begin
      bsy++;
      nedge(1);
    end
    check(rc ? "R7 conversion length" : "R6 conversion length", bsy, tcy(14, div, rc));
    check("R8 done pulse", int'(done), 1);
    check("R8 result", int'(result), int'(data));
    if (mode == 3'b111) check("R4 auto restart", int'(sample_hold), 1);
    nedge(1);
    check("R8 done one cycle", int'(done), 0);
    stop_all();
  endtask

  task automatic trig_test(input logic [2:0] mode, input logic [11:0] data);
    trig_src = mode; clk_div = '0; conv_data = data; enable = 1'b1;
    nedge(1);
    samp_sw = 1'b1;
    nedge(3);
    samp_sw = 1'b0;
    nedge(2);
    check("R5 samp fall ignored", int'(sample_hold), 1);
    if (mode == 3'b001) tmr_strobe = 1'b1; else ext_strobe = 1'b1;
    nedge(1);
    tmr_strobe = 1'b0; ext_strobe = 1'b0;
    nedge(1);
    check("R5 other strobe ignored", int'(conv_busy), 0);
    if (mode == 3'b001) ext_strobe = 1'b1; else tmr_strobe = 1'b1;
    nedge(1);
    tmr_strobe = 1'b0; ext_strobe = 1'b0;
    check("R5 strobe starts conversion", int'(conv_busy), 1);
    nedge(14);
    check("R5 result", int'(result), int'(data));
    stop_all();
  endtask

  initial begin
    int seen, prev, sh, bsy;
    void'($urandom(32'd20240));
    nedge(3);
    // R1
    check("R1 sample_hold", int'(sample_hold), 0);
    check("R1 conv_busy", int'(conv_busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(result), 0);
    rst_n = 1'b1;
    nedge(2);

    // R2: rise without enable does nothing
    samp_sw = 1'b1;
    nedge(3);
    check("R2 no start when disabled", int'(sample_hold), 0);
    samp_sw = 1'b0;
    nedge(1);

    run_conv(3'b000, 0, 0, 0, 12'h123, 5);
    run_conv(3'b000, 0, 3, 0, 12'h456, 2);
    run_conv(3'b000, 0, 4, 0, 12'h789, 1);
    run_conv(3'b000, 0, 63, 0, 12'hFFF, 7);
    run_conv(3'b111, 0, 2, 0, 12'h0F0, 0);
    run_conv(3'b111, 31, 2, 0, 12'h00F, 0);
    run_conv(3'b111, 4, 9, 1, 12'hA5A, 0);
    run_conv(3'b000, 0, 9, 1, 12'h5A5, 3);

    // R7: RC clock stalled
    trig_src = 3'b111; samp_cnt = 5'd2; rc_sel = 1'b1; rc_tick = 1'b0; enable = 1'b1;
    nedge(1); samp_sw = 1'b1; nedge(60);
    check("R7 stalled rc clock holds acquisition", int'(sample_hold), 1);
    stop_all();

    trig_test(3'b001, 12'h3C3);
    trig_test(3'b010, 12'hC3C);

    // R5 reserved code
    trig_src = 3'b100; enable = 1'b1;
    nedge(1); samp_sw = 1'b1; nedge(2); samp_sw = 1'b0;
    tmr_strobe = 1'b1; ext_strobe = 1'b1; nedge(2);
    tmr_strobe = 1'b0; ext_strobe = 1'b0; nedge(8);
    check("R5 reserved code holds acquisition", int'(sample_hold), 1);
    check("R5 reserved code no conversion", int'(conv_busy), 0);
    stop_all();

    // R2: rise during acquisition ignored (sw mode stays in acquisition)
    trig_src = 3'b000; enable = 1'b1;
    nedge(1); samp_sw = 1'b1; nedge(3);
    check("R2 acquisition active", int'(sample_hold), 1);
    stop_all();

    // R9 abort during conversion
    prev = int'(result);
    trig_src = 3'b000; clk_div = 6'd5; conv_data = 12'hABC; enable = 1'b1;
    nedge(1); samp_sw = 1'b1; nedge(3); samp_sw = 1'b0; nedge(5);
    check("R9 converting before abort", int'(conv_busy), 1);
    enable = 1'b0;
    nedge(1);
    check("R9 abort stops conversion", int'(conv_busy), 0);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) seen = 1;
      nedge(1);
    end
    check("R9 no done after abort", seen, 0);
    check("R9 result kept", int'(result), prev);
    enable = 1'b1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (sample_hold) seen = 1;
      nedge(1);
    end
    check("R9 no restart without new rise", seen, 0);
    stop_all();

    // R10 abort coincident with auto-start
    trig_src = 3'b111; samp_cnt = 5'd3; clk_div = 6'd1; enable = 1'b1;
    nedge(1); samp_sw = 1'b1; nedge(1);
    sh = 0;
    while (sample_hold && sh < 100) begin
      sh++;
      if (sh == 3) enable = 1'b0;
      nedge(1);
    end
    check("R10 acquisition length", sh, 3);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (conv_busy || done) seen = 1;
      nedge(1);
    end
    check("R10 no conversion", seen, 0);
    stop_all();

    // R11 software write
    buf_wdata = 12'h5A6; buf_we = 1'b1;
    nedge(1);
    buf_we = 1'b0;
    check("R11 software write", int'(result), 12'h5A6);
    trig_src = 3'b000; clk_div = '0; conv_data = 12'h321; enable = 1'b1;
    nedge(1); samp_sw = 1'b1; nedge(2); samp_sw = 1'b0; nedge(1);
    bsy = 0;
    while (conv_busy && bsy < 100) begin
      bsy++;
      if (bsy == 14) begin buf_we = 1'b1; buf_wdata = 12'h777; end
      nedge(1);
    end
    buf_we = 1'b0;
    check("R11 collision done", int'(done), 1);
    check("R11 conversion wins collision", int'(result), 12'h321);
    stop_all();

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [2:0] m;
      m = ($urandom % 2) ? 3'b111 : 3'b000;
      run_conv(m, int'($urandom % 32), int'($urandom % 64), bit'($urandom % 4 == 0),
               12'($urandom), 1 + int'($urandom % 9));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule